// File: doc/BRIEF.md
# Shared-Bus Quadratic Evaluator

This block evaluates y = a + b·x + c·x² on W-bit unsigned integers. All arithmetic wraps modulo 2^W. It owns one multiplier and one adder. Both reach a single W-bit bus through gated drivers, which stand in for tri-state buffers. Four operand registers take their values from that bus. The multiplier reads the C and D operand registers, and the adder reads the A and B operand registers. The three coefficients sit in a small constant table with a 2-bit address, set by module parameters: entry 0 holds a, entry 1 holds b, entry 2 holds c, and entry 3 reads as zero.

A one-cycle start pulse in idle launches a fixed ten-step schedule. Each step makes one bus transfer, and each step takes one clock. The steps are: load x into C and D; square it; fetch c; form c·x² into B; reload x; fetch b; form b·x into A; add to B; fetch a into A; add into Y. After the last step the result register Y changes, a done flag is high for one cycle, and the controller returns to idle. Y keeps its value until the next evaluation ends. Start pulses that arrive during a run are ignored. The input x must stay stable for the whole run.

Top module: `quad_seq_eval`

## Requirements
- R1: While rst_n is low, and after it is released, y_out reads 0 and done reads 0 until an evaluation completes. A reset in the middle of a run abandons the run, and no done follows.
- R2: In every cycle at most one source drives the shared bus. In idle none drives it, and in each of the ten steps exactly one drives it.
- R3: The value loaded into y_out equals COEF_A + COEF_B·x + COEF_C·x² modulo 2^W. The multiplier and adder keep the low W bits.
- R4: A start captured in idle is at clock edge e0. Then done is high for exactly the one cycle after edge e0+10, and y_out takes the new value at that same edge.
- R5: A start that is high while a run is in progress is ignored. This includes a start during the final step. Such a start changes neither the result nor the timing of the current run, and it launches no later run.
- R6: y_out changes only at the edge that raises done. Between runs it holds its value.
- R7: Intermediate products and sums wrap on overflow. For example, with a=2, b=4 and c=6, the input x=0x80000000 gives 2, and x=0xFFFFFFFF gives 4.
- R8: A start that is high in the cycle where done is high is taken, because the controller is idle then. That start begins a new run.
- R9: The coefficients come only from the parameters COEF_A, COEF_B and COEF_C. A second instance with different values computes its own polynomial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, honoured only in idle |
| x_in | input | W | Polynomial argument, held stable during a run |
| y_out | output | W | Result register |
| done | output | 1 | One-cycle pulse when y_out is updated |

## Verification
The bound checker watches these every clock:
- the bus is never driven by two sources at once, and in each busy step it is driven by exactly one (R2);
- done lasts a single cycle and comes exactly ten cycles after an accepted start (R4);
- y_out never changes except with done (R6).

The arithmetic itself (R3, R7, R9) can only be shown by the bench's scenarios, which compare the result against values worked out by hand or by a function in the bench. The same holds for start being ignored while busy (R5), back-to-back launches (R8) and reset in the middle of a run (R1).

// File: rtl/qe_pkg.sv
package qe_pkg;
   localparam int NDRV    = 4;
   localparam int DRV_X   = 0;
   localparam int DRV_MUL = 1;
   localparam int DRV_ADD = 2;
   localparam int DRV_ROM = 3;

   localparam int NREG  = 5;
   localparam int REG_A = 0;
   localparam int REG_B = 1;
   localparam int REG_C = 2;
   localparam int REG_D = 3;
   localparam int REG_Y = 4;

   localparam logic [1:0] ROM_A = 2'd0;
   localparam logic [1:0] ROM_B = 2'd1;
   localparam logic [1:0] ROM_C = 2'd2;

   typedef enum logic [3:0] {
      ST_0 = 4'd0, ST_1 = 4'd1, ST_2 = 4'd2, ST_3 = 4'd3, ST_4 = 4'd4,
      ST_5 = 4'd5, ST_6 = 4'd6, ST_7 = 4'd7, ST_8 = 4'd8, ST_9 = 4'd9,
      ST_IDLE = 4'd15
   } qe_state_t;
endpackage

// File: rtl/qe_coef_rom.sv
module qe_coef_rom #(
   parameter int             W      = 32,
   parameter logic [W-1:0]   COEF_A = '0,
   parameter logic [W-1:0]   COEF_B = '0,
   parameter logic [W-1:0]   COEF_C = '0
) (
   input  logic [1:0]   addr,
   output logic [W-1:0] data
);
   import qe_pkg::*;

   always_comb begin
      case (addr)
         ROM_A:   data = COEF_A;
         ROM_B:   data = COEF_B;
         ROM_C:   data = COEF_C;
         default: data = '0;
      endcase
   end
endmodule

// File: rtl/qe_sequencer.sv
module qe_sequencer
   import qe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [NDRV-1:0]  drv_en,
   output logic [NREG-1:0]  ld_en,
   output logic [1:0]       rom_addr,
   output logic             busy,
   output logic             done
);
   qe_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (start) state <= ST_0;
            ST_9: begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default: state <= qe_state_t'(state + 4'd1);
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

   always_comb begin
      drv_en   = '0;
      ld_en    = '0;
      rom_addr = ROM_A;
      case (state)
         ST_0: begin drv_en[DRV_X]   = 1'b1; ld_en[REG_C] = 1'b1; ld_en[REG_D] = 1'b1; end
         ST_1: begin drv_en[DRV_MUL] = 1'b1; ld_en[REG_C] = 1'b1; end
         ST_2: begin drv_en[DRV_ROM] = 1'b1; rom_addr = ROM_C; ld_en[REG_D] = 1'b1; end
         ST_3: begin drv_en[DRV_MUL] = 1'b1; ld_en[REG_B] = 1'b1; end
         ST_4: begin drv_en[DRV_X]   = 1'b1; ld_en[REG_C] = 1'b1; end
         ST_5: begin drv_en[DRV_ROM] = 1'b1; rom_addr = ROM_B; ld_en[REG_D] = 1'b1; end
         ST_6: begin drv_en[DRV_MUL] = 1'b1; ld_en[REG_A] = 1'b1; end
         ST_7: begin drv_en[DRV_ADD] = 1'b1; ld_en[REG_B] = 1'b1; end
         ST_8: begin drv_en[DRV_ROM] = 1'b1; rom_addr = ROM_A; ld_en[REG_A] = 1'b1; end
         ST_9: begin drv_en[DRV_ADD] = 1'b1; ld_en[REG_Y] = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/qe_datapath.sv
module qe_datapath
   import qe_pkg::*;
#(
   parameter int           W      = 32,
   parameter logic [W-1:0] COEF_A = '0,
   parameter logic [W-1:0] COEF_B = '0,
   parameter logic [W-1:0] COEF_C = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NDRV-1:0]  drv_en,
   input  logic [NREG-1:0]  ld_en,
   input  logic [1:0]       rom_addr,
   input  logic [W-1:0]     x_in,
   output logic [W-1:0]     y_out
);
   logic [W-1:0] regs   [NREG];
   logic [W-1:0] src    [NDRV];
   logic [W-1:0] gated  [NDRV];
   logic [W-1:0] rom_q;
   logic [W-1:0] bus;

   qe_coef_rom #(.W(W), .COEF_A(COEF_A), .COEF_B(COEF_B), .COEF_C(COEF_C)) u_rom (
      .addr (rom_addr),
      .data (rom_q)
   );

   assign src[DRV_X]   = x_in;
   assign src[DRV_MUL] = regs[REG_C] * regs[REG_D];
   assign src[DRV_ADD] = regs[REG_A] + regs[REG_B];
   assign src[DRV_ROM] = rom_q;

   for (genvar s = 0; s < NDRV; s++) begin : g_drv
      assign gated[s] = drv_en[s] ? src[s] : '0;
   end

   always_comb begin
      bus = '0;
      for (int s = 0; s < NDRV; s++) bus = bus | gated[s];
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        regs[r] <= '0;
         else if (ld_en[r]) regs[r] <= bus;
      end
   end

   assign y_out = regs[REG_Y];
endmodule

// File: rtl/quad_seq_eval.sv
module quad_seq_eval #(
   parameter int           W      = 32,
   parameter logic [W-1:0] COEF_A = W'(2),
   parameter logic [W-1:0] COEF_B = W'(4),
   parameter logic [W-1:0] COEF_C = W'(6)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] x_in,
   output logic [W-1:0] y_out,
   output logic         done
);
   import qe_pkg::*;

   if (W < 4) begin : g_bad_width
      $error("quad_seq_eval: W must be at least 4");
   end

   logic [NDRV-1:0] drv_en;
   logic [NREG-1:0] ld_en;
   logic [1:0]      rom_addr;
   logic            busy;

   qe_sequencer u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .drv_en   (drv_en),
      .ld_en    (ld_en),
      .rom_addr (rom_addr),
      .busy     (busy),
      .done     (done)
   );

   qe_datapath #(.W(W), .COEF_A(COEF_A), .COEF_B(COEF_B), .COEF_C(COEF_C)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .drv_en   (drv_en),
      .ld_en    (ld_en),
      .rom_addr (rom_addr),
      .x_in     (x_in),
      .y_out    (y_out)
   );
endmodule

// File: rtl/qe_checker.sv
module qe_checker #(
   parameter int W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start,
   input logic                      done,
   input logic [W-1:0]              y_out,
   input logic [qe_pkg::NDRV-1:0]   drv_en,
   input logic                      busy
);
   logic [4:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_cnt <= '0;
      else if (!busy && start) run_cnt <= '0;
      else if (busy)           run_cnt <= run_cnt + 5'd1;
   end

   assert_bus_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_en));
   assert_busy_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $onehot(drv_en));
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (drv_en == '0));
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == 5'd10));
   assert_y_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(y_out) |-> done);
endmodule

bind quad_seq_eval qe_checker #(.W(W)) u_qe_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .done   (done),
   .y_out  (y_out),
   .drv_en (drv_en),
   .busy   (busy)
);

// File: tb/quad_seq_eval_bench.sv
module quad_seq_eval_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [31:0] x_in;
   logic [31:0] y_out, y_alt;
   logic        done, done_alt;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   quad_seq_eval u_quad_seq_eval (
      .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_out(y_out), .done(done));

   quad_seq_eval #(.W(32), .COEF_A(32'd7), .COEF_B(32'd0), .COEF_C(32'd1)) u_quad_seq_eval_alt (
      .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_out(y_alt), .done(done_alt));

   // {x, expected y for a=2, b=4, c=6}
   localparam int NVEC = 7;
   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0000_0000, 32'd2},
      {32'h0000_0001, 32'd12},
      {32'h0000_0003, 32'd68},
      {32'h0000_000A, 32'd642},
      {32'hFFFF_FFFF, 32'd4},
      {32'h0001_0000, 32'h0004_0002},
      {32'h8000_0000, 32'd2}
   };

   function automatic logic [31:0] alt_model(input logic [31:0] xv);
      return 32'd7 + xv * xv;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // start is driven from the current negedge; returns the negedge index where done is seen
   task automatic run_eval(input logic [31:0] xv, input int busy_poke, output int seen);
      x_in  = xv;
      start = 1'b1;
      seen  = 0;
      for (int n = 1; n <= 20; n++) begin
         @(negedge clk);
         start = (n == busy_poke) || (n == 10 && busy_poke > 0);
         if (done) begin
            seen  = n;
            start = 1'b0;
            break;
         end
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      finished = 1'b1;
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
         finish_run();
      end
   end

   initial begin
      int seen;
      logic [31:0] held;
      rst_n = 1'b0;
      start = 1'b0;
      x_in  = '0;
      repeat (3) @(negedge clk);
      check(y_out == 32'd0, "R1 reset y", y_out, 32'd0);
      check(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(y_out == 32'd0 && !done, "R1 after release", y_out, 32'd0);

      // R3 R7 R9 R4: table walk
      for (int i = 0; i < NVEC; i++) begin
         run_eval(VEC[i][63:32], 0, seen);
         check(seen == 11, "R4 done latency", 32'(seen), 32'd11);
         check(y_out == VEC[i][31:0], (i >= 4) ? "R7 wrap result" : "R3 result",
               y_out, VEC[i][31:0]);
         check(y_alt == alt_model(VEC[i][63:32]), "R9 alt coefficients",
               y_alt, alt_model(VEC[i][63:32]));
         @(negedge clk);
         check(!done, "R4 done single cycle", 32'(done), 32'd0);
      end

      // R5: start pulses during run (step 3 and final step) are ignored
      run_eval(32'd5, 3, seen);
      check(seen == 11, "R5 timing with busy start", 32'(seen), 32'd11);
      check(y_out == 32'd172, "R5 result with busy start", y_out, 32'd172);
      held = y_out;
      x_in = 32'd9;
      seen = 0;
      for (int n = 0; n < 15; n++) begin
         @(negedge clk);
         if (done) seen++;
      end
      check(seen == 0, "R5 no extra run", 32'(seen), 32'd0);
      check(y_out == held, "R6 y holds between runs", y_out, held);

      // R8: back-to-back, start during the done cycle
      run_eval(32'd2, 0, seen);
      check(y_out == 32'd34, "R8 first of pair", y_out, 32'd34);
      run_eval(32'd1, 0, seen);
      check(seen == 11, "R8 second launch latency", 32'(seen), 32'd11);
      check(y_out == 32'd12, "R8 second result", y_out, 32'd12);

      // R1: reset in mid run abandons it
      x_in  = 32'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(y_out == 32'd0 && !done, "R1 mid-run reset", y_out, 32'd0);
      rst_n = 1'b1;
      seen = 0;
      for (int n = 0; n < 15; n++) begin
         @(negedge clk);
         if (done) seen++;
      end
      check(seen == 0, "R1 abandoned run no done", 32'(seen), 32'd0);
      check(y_out == 32'd0, "R1 y stays cleared", y_out, 32'd0);

      finish_run();
   end
endmodule